// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error-Tagged Queue

This block is the receive half of an asynchronous serial port. A clock enable pulses at sixteen times the bit rate, and the block samples the incoming line on those pulses. It validates start bits, assembles characters of 5 to 8 data bits with optional parity, and pushes each character into a 16-entry queue. Every entry in the queue holds the data byte and three error tags: parity, framing and break.

The host side sees the head of the queue, a set of sticky line-status bits and a trigger flag. The trigger flag rises once the queue holds the number of characters chosen by a 2-bit code. A tag becomes visible in the status bits only when its character reaches the head of the queue. Overruns, line breaks and framing-error resynchronisation follow fixed rules. The line can be taken from the external pin or from an internal loopback source.

Top module: `uart_rx_core`

## Requirements
- R1: `stat_ready` is 1 while the queue holds at least one character, and `rd_data` shows the oldest one. A `rd_data_strobe` removes the head. A strobe on an empty queue changes nothing.
- R2: When a character completes while the queue holds 16 entries, `stat_overrun` is set and that character is discarded. The stored entries are unchanged.
- R3: `stat_parity`, `stat_frame` and `stat_break` take a character's tags only when that character becomes the head of the queue. Tags on characters behind the head do not show.
- R4: A 0 sampled at the first stop bit tags the character with a framing error. That low level then counts as the start bit of the next character, whose first data bit is sampled 16 ticks later.
- R5: A frame in which the start bit, all data bits, the parity bit (if enabled) and the stop bit all sample 0 stores exactly one entry: data 0x00 with the break tag set. The receiver then waits for the line to return to 1 before it looks for a new start bit.
- R6: `stat_overrun`, `stat_parity`, `stat_frame` and `stat_break` are sticky. A `rd_status_strobe` clears them.
- R7: `stat_fifo_err` is set while any stored entry carries a tag. A status read clears it only when no tagged entry remains.
- R8: `trig_hit` is 1 when the number of stored entries is at least the level chosen by `trig_code`: code 0 means 1, code 1 means 4, code 2 means 8 and code 3 means 14.
- R9: `fifo_clear` empties the queue in the next cycle. A character that is being shifted in at that moment is still completed and stored.
- R10: A start bit counts only if the line is still 0 eight ticks after the falling edge. A shorter low pulse stores nothing.
- R11: `word_len` codes 0..3 select 5..8 data bits, sent LSB first and zero-extended in `rd_data`. With `par_en` set, the expected parity bit is as follows. When `par_stick` is 0, `par_even`=1 gives even parity and 0 gives odd parity. When `par_stick` is 1, the expected bit is the inverse of `par_even`. A mismatch sets the parity tag.
- R12: With `loop_en` set, the receiver samples `loop_in` and ignores `serial_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Enable at 16x the bit rate |
| serial_in | input | 1 | External serial line |
| loop_in | input | 1 | Internal loopback line |
| loop_en | input | 1 | Select loopback line |
| word_len | input | 2 | Data bits minus 5 |
| par_en | input | 1 | Parity bit present |
| par_even | input | 1 | Even parity select |
| par_stick | input | 1 | Fixed parity value |
| trig_code | input | 2 | Trigger level code |
| rd_data_strobe | input | 1 | Pop head of queue |
| rd_status_strobe | input | 1 | Status read, clears sticky bits |
| fifo_clear | input | 1 | Empty the queue |
| rd_data | output | 8 | Head character |
| stat_ready | output | 1 | Queue not empty |
| stat_overrun | output | 1 | Overrun occurred |
| stat_parity | output | 1 | Head had parity error |
| stat_frame | output | 1 | Head had framing error |
| stat_break | output | 1 | Head was a break |
| stat_fifo_err | output | 1 | Tagged entry stored |
| trig_hit | output | 1 | Trigger level reached |

## Verification
The bench targets several corner cases, and each has a clear failure mode if handled wrong:
- **Tag timing.** A receiver that shows tags at arrival rather than at the head would flag a clean character that sits in front of a bad one.
- **Overrun.** An overrun that overwrites the last entry, rather than dropping the new character, would make the 16th read return the wrong byte.
- **Framing resynchronisation.** A receiver that hunts for a fresh falling edge after a bad stop bit would lose or garble the character that follows.
- **Break.** A receiver that restarts on every low frame during a long break would fill the queue with zero bytes.
- **Queue clear.** The bench also clears the queue in the middle of a frame, which catches a design that resets its shift logic together with the queue.
- **Short glitch.** It sends a low pulse shorter than half a bit, which catches a design that stores a character on any falling edge.

// File: rtl/urx_pkg.sv
package urx_pkg;
  typedef struct packed {
    logic       brk;
    logic       frm;
    logic       par;
    logic [7:0] data;
  } urx_entry_t;

  localparam int ENTRY_W = $bits(urx_entry_t);

  function automatic logic [4:0] trig_level(input logic [1:0] code);
    case (code)
      2'd0:    trig_level = 5'd1;
      2'd1:    trig_level = 5'd4;
      2'd2:    trig_level = 5'd8;
      default: trig_level = 5'd14;
    endcase
  endfunction
endpackage

// File: rtl/urx_deser.sv
module urx_deser
  import urx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       line,
  input  logic [1:0] word_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  output logic       push_o,
  output urx_entry_t entry_o
);
  localparam int CNTW = $clog2(OSR);
  localparam int HALF = OSR / 2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK} st_t;
  st_t             st;
  logic [CNTW-1:0] cnt;
  logic [2:0]      idx;
  logic [7:0]      dat;
  logic            pbit;
  logic            exp_par;
  logic            last_idx;
  logic            at_bit;

  always_comb begin
    if (par_stick) exp_par = ~par_even;
    else           exp_par = par_even ? ^dat : ~^dat;
    last_idx = (idx == ({1'b0, word_len} + 3'd4));
    at_bit   = (cnt == CNTW'(OSR - 1));
  end

  always_ff @(posedge clk) begin
    push_o <= 1'b0;
    if (rst) begin
      st      <= S_IDLE;
      cnt     <= '0;
      idx     <= '0;
      dat     <= '0;
      pbit    <= 1'b0;
      entry_o <= '0;
    end else if (tick) begin
      case (st)
        S_IDLE: if (!line) begin
          st  <= S_START;
          cnt <= '0;
        end
        S_START: begin
          if (cnt == CNTW'(HALF - 1)) begin
            cnt <= '0;
            idx <= '0;
            dat <= '0;
            st  <= line ? S_IDLE : S_DATA;
          end else cnt <= cnt + 1'b1;
        end
        S_DATA: begin
          if (at_bit) begin
            cnt      <= '0;
            dat[idx] <= line;
            if (last_idx) st <= par_en ? S_PAR : S_STOP;
            else          idx <= idx + 3'd1;
          end else cnt <= cnt + 1'b1;
        end
        S_PAR: begin
          if (at_bit) begin
            cnt  <= '0;
            pbit <= line;
            st   <= S_STOP;
          end else cnt <= cnt + 1'b1;
        end
        S_STOP: begin
          if (at_bit) begin
            cnt          <= '0;
            push_o       <= 1'b1;
            entry_o.data <= dat;
            entry_o.par  <= par_en && (pbit != exp_par);
            entry_o.frm  <= 1'b0;
            entry_o.brk  <= 1'b0;
            if (line) begin
              st <= S_IDLE;
            end else if (dat == 8'd0 && !(par_en && pbit)) begin
              entry_o.par <= 1'b0;
              entry_o.brk <= 1'b1;
              st          <= S_BRK;
            end else begin
              entry_o.frm <= 1'b1;
              idx         <= '0;
              dat         <= '0;
              st          <= S_DATA;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_BRK: if (line) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/urx_fifo.sv
module urx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 11
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       wr_en,
  input  logic [W-1:0]               wdata,
  input  logic                       rd_en,
  output logic [W-1:0]               rdata,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       fresh
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp] <= wdata;
  end

  assign rdata = mem[rp];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      fresh <= 1'b0;
    end else begin
      if (wr_en) wp <= wp + 1'b1;
      if (rd_en) rp <= rp + 1'b1;
      count <= count + CW'(wr_en) - CW'(rd_en);
      fresh <= (wr_en && (count == '0 || (rd_en && count == CW'(1))))
            || (rd_en && count > CW'(1));
    end
  end
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import urx_pkg::*;
#(
  parameter int OSR   = 16,
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       serial_in,
  input  logic       loop_in,
  input  logic       loop_en,
  input  logic [1:0] word_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       par_stick,
  input  logic [1:0] trig_code,
  input  logic       rd_data_strobe,
  input  logic       rd_status_strobe,
  input  logic       fifo_clear,
  output logic [7:0] rd_data,
  output logic       stat_ready,
  output logic       stat_overrun,
  output logic       stat_parity,
  output logic       stat_frame,
  output logic       stat_break,
  output logic       stat_fifo_err,
  output logic       trig_hit
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [1:0]    sync_q;
  logic          d_push;
  urx_entry_t    d_entry;
  urx_entry_t    head;
  logic [CW-1:0] count;
  logic          fresh;
  logic          full, wr_ok, rd_ok, ovr_set;
  logic [CW-1:0] err_cnt;
  logic          w_flag, h_flag;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= 2'b11;
    else     sync_q <= {sync_q[0], loop_en ? loop_in : serial_in};
  end

  urx_deser #(.OSR(OSR)) u_deser (
    .clk(clk), .rst(rst), .tick(tick), .line(sync_q[1]),
    .word_len(word_len), .par_en(par_en), .par_even(par_even),
    .par_stick(par_stick), .push_o(d_push), .entry_o(d_entry)
  );

  always_comb begin
    full    = (count == CW'(DEPTH));
    wr_ok   = d_push && !full && !fifo_clear;
    rd_ok   = rd_data_strobe && count != '0 && !fifo_clear;
    ovr_set = d_push && full && !fifo_clear;
    w_flag  = d_entry.par | d_entry.frm | d_entry.brk;
    h_flag  = head.par | head.frm | head.brk;
  end

  urx_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk(clk), .rst(rst), .clr(fifo_clear), .wr_en(wr_ok), .wdata(d_entry),
    .rd_en(rd_ok), .rdata(head), .count(count), .fresh(fresh)
  );

  always_ff @(posedge clk) begin
    if (rst || fifo_clear) err_cnt <= '0;
    else err_cnt <= err_cnt + CW'(wr_ok && w_flag) - CW'(rd_ok && h_flag);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_overrun  <= 1'b0;
      stat_parity   <= 1'b0;
      stat_frame    <= 1'b0;
      stat_break    <= 1'b0;
      stat_fifo_err <= 1'b0;
    end else begin
      stat_overrun  <= (stat_overrun & ~rd_status_strobe) | ovr_set;
      stat_parity   <= (stat_parity  & ~rd_status_strobe) | (fresh & head.par);
      stat_frame    <= (stat_frame   & ~rd_status_strobe) | (fresh & head.frm);
      stat_break    <= (stat_break   & ~rd_status_strobe) | (fresh & head.brk);
      stat_fifo_err <= (err_cnt != '0) | (stat_fifo_err & ~rd_status_strobe);
    end
  end

  assign rd_data    = head.data;
  assign stat_ready = (count != '0);
  assign trig_hit   = (count >= CW'(trig_level(trig_code)));
endmodule

// File: rtl/uart_rx_core_chk.sv
module uart_rx_core_chk (
  input logic clk,
  input logic rst,
  input logic fifo_clear,
  input logic rd_data_strobe,
  input logic rd_status_strobe,
  input logic stat_ready,
  input logic stat_overrun,
  input logic trig_hit,
  input logic ovr_set
);
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    fifo_clear |=> !stat_ready); // R9
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    stat_overrun && !rd_status_strobe |=> stat_overrun); // R2
  AST_OVR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rd_status_strobe && !ovr_set |=> !stat_overrun); // R6
  AST_TRIG_NEEDS_DATA: assert property (@(posedge clk) disable iff (rst)
    trig_hit |-> stat_ready); // R8
  AST_READY_DROP: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_ready) |-> $past(rd_data_strobe || fifo_clear)); // R1
endmodule

bind uart_rx_core uart_rx_core_chk u_chk (
  .clk(clk), .rst(rst), .fifo_clear(fifo_clear), .rd_data_strobe(rd_data_strobe),
  .rd_status_strobe(rd_status_strobe), .stat_ready(stat_ready),
  .stat_overrun(stat_overrun), .trig_hit(trig_hit), .ovr_set(ovr_set)
);

// File: tb/uart_rx_core_tb.sv
`timescale 1ns/1ps
module uart_rx_core_tb;
  logic clk = 0, rst = 1, tick = 1;
  logic serial_in = 1, loop_in = 1, loop_en = 0;
  logic [1:0] word_len = 2'd3, trig_code = 2'd0;
  logic par_en = 0, par_even = 0, par_stick = 0;
  logic rd_data_strobe = 0, rd_status_strobe = 0, fifo_clear = 0;
  logic [7:0] rd_data;
  logic stat_ready, stat_overrun, stat_parity, stat_frame, stat_break, stat_fifo_err, trig_hit;
  int total = 0, bad = 0;
  bit use_loop = 0, done = 0;

  always #2 clk = ~clk;

  uart_rx_core u_dut (.*);

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit par_bit(input logic [7:0] d, input bit even, input bit stick);
    if (stick) return !even;
    return even ? ^d : !(^d);
  endfunction

  function automatic int lvl(input int c);
    case (c) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
  endfunction

  task automatic send_bit(input logic b);
    if (use_loop) loop_in = b; else serial_in = b;
    repeat (16) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input int nb, input bit pb, input bit stopv);
    send_bit(0);
    for (int i = 0; i < nb; i++) send_bit(d[i]);
    if (par_en) send_bit(pb);
    send_bit(stopv);
  endtask

  task automatic send8(input logic [7:0] d);
    send_frame(d, 8, 0, 1);
  endtask

  task automatic pulse_rd();
    rd_data_strobe = 1; @(negedge clk); rd_data_strobe = 0; repeat (2) @(negedge clk);
  endtask

  task automatic pulse_st();
    rd_status_strobe = 1; @(negedge clk); rd_status_strobe = 0; repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    repeat (5) @(negedge clk);
    rst = 0;
    repeat (4) @(negedge clk);
    // reset state
    check("R1 reset ready", stat_ready, 0);
    check("R8 reset trig", trig_hit, 0);
    check("R6 reset status", {stat_overrun, stat_parity, stat_frame, stat_break, stat_fifo_err}, 0);

    // R1 empty read has no effect
    pulse_rd();
    send8(8'hA5); send_bit(1);
    check("R1 ready after char", stat_ready, 1);
    check("R1 data", rd_data, 8'hA5);
    pulse_rd();
    check("R1 ready after pop", stat_ready, 0);

    // R10 short glitch ignored
    serial_in = 0; repeat (5) @(negedge clk); serial_in = 1;
    repeat (200) @(negedge clk);
    check("R10 glitch ignored", stat_ready, 0);

    // R11 random formats
    for (int t = 0; t < 40; t++) begin
      int nb; bit corrupt, pb; logic [7:0] d;
      word_len = 2'($urandom % 4); nb = 5 + int'(word_len);
      par_en = 1'($urandom); par_even = 1'($urandom); par_stick = 1'($urandom);
      d = 8'($urandom) & 8'((1 << nb) - 1);
      if (d == 0) d = 8'h01;
      corrupt = ($urandom % 4) == 0;
      pb = par_bit(d, par_even, par_stick) ^ corrupt;
      @(negedge clk);
      send_frame(d, nb, pb, 1); send_bit(1);
      check("R11 ready", stat_ready, 1);
      check("R11 data", rd_data, d);
      check("R11 parity tag", stat_parity, int'(par_en && corrupt));
      pulse_st();
      check("R6 parity cleared", stat_parity, 0);
      pulse_rd();
      pulse_st();
    end
    word_len = 2'd3; par_en = 0;
    @(negedge clk);

    // R3 / R7 head-only tags
    send8(8'h11);
    par_en = 1; par_even = 1; par_stick = 0;
    send_frame(8'h22, 8, !par_bit(8'h22, 1, 0), 1); send_bit(1);
    par_en = 0;
    check("R3 clean head no parity", stat_parity, 0);
    check("R7 summary with tagged entry behind", stat_fifo_err, 1);
    pulse_st();
    check("R7 summary kept while tagged stored", stat_fifo_err, 1);
    pulse_rd();
    check("R3 second char data", rd_data, 8'h22);
    check("R3 tag at head", stat_parity, 1);
    pulse_rd();
    check("R7 summary held until read", stat_fifo_err, 1);
    pulse_st();
    check("R7 summary cleared", stat_fifo_err, 0);

    // R4 framing error and resync
    send_bit(0);
    for (int i = 0; i < 8; i++) send_bit(8'h5C >> i);
    send_bit(0);
    for (int i = 0; i < 8; i++) send_bit(8'h3A >> i);
    send_bit(1); send_bit(1);
    check("R4 first data", rd_data, 8'h5C);
    check("R4 frame tag", stat_frame, 1);
    pulse_st(); pulse_rd();
    check("R4 resynced char", rd_data, 8'h3A);
    check("R4 resynced clean", stat_frame, 0);
    pulse_rd();
    check("R4 two entries only", stat_ready, 0);

    // R5 break
    serial_in = 0; repeat (400) @(negedge clk);
    serial_in = 1; repeat (48) @(negedge clk);
    check("R5 break stored", stat_ready, 1);
    check("R5 break data", rd_data, 0);
    check("R5 break tag", stat_break, 1);
    pulse_st(); pulse_rd();
    check("R5 single entry", stat_ready, 0);

    // R8 trigger levels
    for (int c = 0; c < 4; c++) begin
      trig_code = 2'(c);
      fifo_clear = 1; @(negedge clk); fifo_clear = 0;
      for (int k = 0; k < lvl(c) - 1; k++) send8(8'(k));
      send_bit(1);
      check("R8 below level", trig_hit, 0);
      send8(8'hEE); send_bit(1);
      check("R8 at level", trig_hit, 1);
    end
    fifo_clear = 1; @(negedge clk); fifo_clear = 0; @(negedge clk);
    check("R9 clear empties", stat_ready, 0);
    pulse_st();

    // R2 overrun
    for (int k = 0; k < 17; k++) send8(8'(8'h40 + k));
    send_bit(1);
    check("R2 overrun set", stat_overrun, 1);
    for (int k = 0; k < 16; k++) begin
      check("R2 stored data", rd_data, 8'h40 + k);
      pulse_rd();
    end
    check("R2 new char dropped", stat_ready, 0);
    check("R2 overrun sticky", stat_overrun, 1);
    pulse_st();
    check("R6 overrun cleared", stat_overrun, 0);

    // R9 clear mid-frame keeps shift register
    send8(8'h77);
    send_bit(0);
    for (int i = 0; i < 4; i++) send_bit(8'h9B >> i);
    fifo_clear = 1; @(negedge clk); fifo_clear = 0;
    for (int i = 4; i < 8; i++) send_bit(8'h9B >> i);
    send_bit(1); send_bit(1);
    check("R9 char after clear", rd_data, 8'h9B);
    pulse_rd();
    check("R9 old entry gone", stat_ready, 0);

    // R12 loopback
    loop_en = 1; use_loop = 1; serial_in = 0;
    repeat (4) @(negedge clk);
    send8(8'hC3); send_bit(1);
    check("R12 loop data", rd_data, 8'hC3);
    check("R12 serial ignored", stat_break, 0);
    pulse_rd();
    check("R12 one entry", stat_ready, 0);
    serial_in = 1; loop_en = 0; use_loop = 0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule